// File: doc/BRIEF.md
# Signed Rounding Stage with Selectable Policy

This block narrows a signed two's complement sample from a wide internal width to a narrower one. It sits between the stages of a pipelined FFT datapath. In that datapath, extra fractional bits are carried through the arithmetic and dropped only where the width must shrink. The number of bits removed is the difference between the input and output widths. The way they are removed is fixed when the block is built, by a parameter that selects one of four policies.

The four policies are plain truncation, round-half-up, round-half-away-from-zero and round-half-to-even (convergent). In every policy except truncation, the stage first decides whether the removed fraction is below one half, exactly one half, or above one half. Exact halves are then resolved by the selected policy. If rounding up would push the largest positive kept value past the output range, the result is clamped to the largest positive code.

The stage has a single register with one cycle of latency. A frame-start flag passes through the same register, so it stays aligned with its sample. A clock enable freezes both the data and the flag. An asynchronous active-low reset clears both.

Top module: `sig_round_stage`

## Requirements
- R1: While `rst_n` is low, `o_data` is zero and `o_sync` is zero, and asserting `rst_n` low clears any pending sync flag at once.
- R2: With MODE = 0 (truncate), `o_data` equals the input shifted right arithmetically by IW-OW bits (floor of input / 2^(IW-OW)).
- R3: With MODE = 1 (half-up), the kept value is incremented whenever the most significant removed bit, `i_data[IW-OW-1]`, is 1, for either sign.
- R4: With MODE = 2 (away from zero), a removed part equal to exactly one half (top removed bit 1, all lower removed bits 0) rounds up for a non-negative input (`i_data[IW-1]` = 0) and down for a negative one.
- R5: With MODE = 3 (convergent), a removed part equal to exactly one half rounds to whichever neighbouring kept value is even.
- R6: In MODE 2 and MODE 3, a removed part above one half rounds up and a removed part below one half rounds down.
- R7: Whenever the selected policy would round up from the largest positive output code 2^(OW-1)-1, the output is that code, and a non-negative input never yields a negative output.
- R8: A sample presented with `ce` high at a rising clock edge appears on `o_data` after exactly that edge and not before.
- R9: `o_sync` reproduces `i_sync` with the same one-cycle delay as the data, so it marks the same sample.
- R10: While `ce` is low, `o_data` and `o_sync` keep their values whatever `i_data` and `i_sync` do.
- R11: The policies behave as stated when only one bit is removed (IW-OW = 1), where every odd input is an exact half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable; low holds the output register |
| i_data | input | IW | Wide signed input sample |
| i_sync | input | 1 | Frame-start flag for the input sample |
| o_data | output | OW | Narrowed signed sample, one cycle later |
| o_sync | output | 1 | Frame-start flag aligned to `o_data` |

## Verification
The bench builds the stage eight times, once for each policy at two sizes. The IW=8, OW=4 build removes four bits, so a sweep of all 256 input codes covers every exact half of both signs and every case that saturates at +7. The IW=10, OW=9 build removes a single bit, so every odd input is a tie. With this build, convergent rounding can be checked against the parity of the kept value right up to the saturation point.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

  typedef enum logic [1:0] {
    RND_TRUNC   = 2'd0,
    RND_HALF_UP = 2'd1,
    RND_AWAY    = 2'd2,
    RND_CONV    = 2'd3
  } rnd_mode_e;

  // Decide whether the kept value must be bumped by one LSB.
  function automatic logic rnd_want_inc(
    input rnd_mode_e mode,
    input logic      half,
    input logic      tie,
    input logic      above,
    input logic      neg,
    input logic      lsb
  );
    logic r;
    case (mode)
      RND_TRUNC:   r = 1'b0;
      RND_HALF_UP: r = half;
      RND_AWAY:    r = above | (tie & ~neg);
      default:     r = above | (tie & lsb);
    endcase
    return r;
  endfunction

  // Largest positive code of a W-bit signed field, as a mask test.
  function automatic logic rnd_is_maxpos(input logic sign, input logic all_low_ones);
    return ~sign & all_low_ones;
  endfunction

endpackage

// File: rtl/rnd_frac_classify.sv
module rnd_frac_classify #(
  parameter int DW = 4
) (
  input  logic [DW-1:0] frac,
  output logic          half,
  output logic          tie,
  output logic          above
);
  logic rest_zero;

  assign half = frac[DW-1];

  generate
    if (DW == 1) begin : g_single
      assign rest_zero = 1'b1;
    end else begin : g_multi
      assign rest_zero = (frac[DW-2:0] == '0);
    end
  endgenerate

  assign tie   = half & rest_zero;
  assign above = half & ~rest_zero;
endmodule

// File: rtl/rnd_inc_select.sv
module rnd_inc_select
  import rnd_pkg::*;
#(
  parameter rnd_mode_e MODE = RND_CONV
) (
  input  logic half,
  input  logic tie,
  input  logic above,
  input  logic neg,
  input  logic lsb,
  output logic inc
);
  assign inc = rnd_want_inc(MODE, half, tie, above, neg, lsb);
endmodule

// File: rtl/rnd_sat_add.sv
module rnd_sat_add
  import rnd_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [W-1:0] kept,
  input  logic         inc,
  output logic [W-1:0] sum,
  output logic         sat
);
  logic low_ones;

  assign low_ones = &kept[W-2:0];
  assign sat      = inc & rnd_is_maxpos(kept[W-1], low_ones);
  assign sum      = kept + W'(inc);
endmodule

// File: rtl/sig_round_stage.sv
module sig_round_stage
  import rnd_pkg::*;
#(
  parameter int        IW   = 16,
  parameter int        OW   = 12,
  parameter rnd_mode_e MODE = RND_CONV
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic [IW-1:0] i_data,
  input  logic          i_sync,
  output logic [OW-1:0] o_data,
  output logic          o_sync
);
  localparam int DW = IW - OW;
  localparam logic [OW-1:0] MAXP = {1'b0, {(OW-1){1'b1}}};

  logic [OW-1:0] rnd_kept;
  logic [DW-1:0] rnd_frac;
  logic          rnd_half;
  logic          rnd_tie;
  logic          rnd_above;
  logic          rnd_inc;
  logic [OW-1:0] rnd_sum;
  logic          rnd_sat;
  logic [OW-1:0] rnd_val;

  assign rnd_kept = i_data[IW-1:DW];
  assign rnd_frac = i_data[DW-1:0];

  rnd_frac_classify #(.DW(DW)) u_cls (
    .frac  (rnd_frac),
    .half  (rnd_half),
    .tie   (rnd_tie),
    .above (rnd_above)
  );

  rnd_inc_select #(.MODE(MODE)) u_sel (
    .half  (rnd_half),
    .tie   (rnd_tie),
    .above (rnd_above),
    .neg   (i_data[IW-1]),
    .lsb   (rnd_kept[0]),
    .inc   (rnd_inc)
  );

  rnd_sat_add #(.W(OW)) u_add (
    .kept (rnd_kept),
    .inc  (rnd_inc),
    .sum  (rnd_sum),
    .sat  (rnd_sat)
  );

  assign rnd_val = rnd_sat ? MAXP : rnd_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_data <= '0;
      o_sync <= 1'b0;
    end else if (ce) begin
      o_data <= rnd_val;
      o_sync <= i_sync;
    end
  end
endmodule

// File: rtl/rnd_stage_chk.sv
module rnd_stage_chk
  import rnd_pkg::*;
#(
  parameter int        IW   = 16,
  parameter int        OW   = 12,
  parameter rnd_mode_e MODE = RND_CONV
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce,
  input logic [IW-1:0] i_data,
  input logic          i_sync,
  input logic [OW-1:0] o_data,
  input logic          o_sync,
  input logic          half,
  input logic          tie,
  input logic          above,
  input logic          inc,
  input logic          sat
);
  localparam int DW = IW - OW;
  localparam logic [OW-1:0] MAXP  = {1'b0, {(OW-1){1'b1}}};
  localparam logic [DW-1:0] HALFC = {1'b1, {(DW-1){1'b0}}};

  a_r2_trunc_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && MODE == RND_TRUNC) |=> o_data == $past(i_data[IW-1:DW]));

  a_r3_half_up: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == RND_HALF_UP) |-> inc == half);

  a_r4_tie_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    tie |-> i_data[DW-1:0] == HALFC);

  a_r6_class_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tie, above}));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !i_data[IW-1]) |=> !o_data[OW-1]);

  a_r7_sat_code: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && sat) |=> o_data == MAXP);

  a_r9_sync_align: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> o_sync == $past(i_sync));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(o_data) && $stable(o_sync)));
endmodule

bind sig_round_stage rnd_stage_chk #(.IW(IW), .OW(OW), .MODE(MODE)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ce     (ce),
  .i_data (i_data),
  .i_sync (i_sync),
  .o_data (o_data),
  .o_sync (o_sync),
  .half   (rnd_half),
  .tie    (rnd_tie),
  .above  (rnd_above),
  .inc    (rnd_inc),
  .sat    (rnd_sat)
);

// File: tb/sig_round_stage_tb_top.sv
`timescale 1ns/1ps
module sig_round_stage_tb_top;
  import rnd_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0;
  logic sy = 1'b0;
  logic [7:0] a_in = '0;
  logic [9:0] b_in = '0;
  logic [3:0] a_out [4];
  logic [8:0] b_out [4];
  logic a_sy [4];
  logic b_sy [4];
  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  for (genvar m = 0; m < 4; m++) begin : g_a
    localparam rnd_mode_e MD = rnd_mode_e'(m);
    sig_round_stage #(.IW(8), .OW(4), .MODE(MD)) dut_i (
      .clk(clk), .rst_n(rst_n), .ce(ce), .i_data(a_in), .i_sync(sy),
      .o_data(a_out[m]), .o_sync(a_sy[m]));
  end
  for (genvar m = 0; m < 4; m++) begin : g_b
    localparam rnd_mode_e MD = rnd_mode_e'(m);
    sig_round_stage #(.IW(10), .OW(9), .MODE(MD)) dut_i (
      .clk(clk), .rst_n(rst_n), .ce(ce), .i_data(b_in), .i_sync(sy),
      .o_data(b_out[m]), .o_sync(b_sy[m]));
  end

  // Reference: q = floor(v/2^d), r = remainder, decide by policy, then clamp.
  function automatic int ref_raw(int v, int d, int mode);
    int q, r, h;
    q = v >>> d;
    r = v - q * (1 << d);
    h = 1 << (d - 1);
    case (mode)
      0: return q;
      1: return q + ((r >= h) ? 1 : 0);
      2: return (r > h || (r == h && v >= 0)) ? q + 1 : q;
      default: return (r > h || (r == h && (q % 2 != 0))) ? q + 1 : q;
    endcase
  endfunction

  function automatic int clampv(int x, int ow);
    int mx;
    mx = (1 << (ow - 1)) - 1;
    return (x > mx) ? mx : x;
  endfunction

  function automatic string tag_of(int v, int d, int ow, int mode);
    int q, r, mx;
    q = v >>> d;
    r = v - q * (1 << d);
    mx = (1 << (ow - 1)) - 1;
    if (ref_raw(v, d, mode) > mx) return "R7";
    if (d == 1 && mode != 0) return "R11";
    case (mode)
      0: return "R2";
      1: return "R3";
      2: return (r == (1 << (d - 1))) ? "R4" : "R6";
      default: return (r == (1 << (d - 1))) ? "R5" : "R6";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_a(int v);
    for (int m = 0; m < 4; m++)
      chk(tag_of(v, 4, 4, m), int'($signed(a_out[m])),
          clampv(ref_raw(v, 4, m), 4), $sformatf("A mode %0d in %0d", m, v));
  endtask

  task automatic check_b(int v);
    for (int m = 0; m < 4; m++)
      chk(tag_of(v, 1, 9, m), int'($signed(b_out[m])),
          clampv(ref_raw(v, 1, m), 9), $sformatf("B mode %0d in %0d", m, v));
  endtask

  // R1: outputs cleared while reset is held
  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      chk("R1", int'(a_out[m]), 0, "A data in reset");
      chk("R1", int'(a_sy[m]), 0, "A sync in reset");
      chk("R1", int'(b_out[m]), 0, "B data in reset");
    end
    rst_n = 1'b1;
    ce = 1'b1;
  endtask

  // R2..R7: every 8-bit code through all four policies
  task automatic t_sweep_a();
    sy = 1'b0;
    for (int x = 0; x < 256; x++) begin
      @(negedge clk);
      a_in = 8'(x);
      @(negedge clk);
      check_a(int'($signed(8'(x))));
    end
  endtask

  // R11: single removed bit, corners plus pseudo-random codes
  task automatic t_sweep_b();
    int corners [14] = '{0, 1, -1, 3, -3, 5, -5, 2, -2, 509, 510, 511, -512, -511};
    int v;
    for (int i = 0; i < 214; i++) begin
      v = (i < 14) ? corners[i] : (int'($urandom_range(0, 1023)) - 512);
      @(negedge clk);
      b_in = 10'(v);
      @(negedge clk);
      check_b(v);
    end
  endtask

  // R8, R9: exact one-cycle latency, sync aligned with its sample
  task automatic t_latency_sync();
    @(negedge clk);
    a_in = 8'h70; sy = 1'b0;
    @(negedge clk);
    a_in = 8'h35; sy = 1'b1;
    #1;
    for (int m = 0; m < 4; m++) begin
      chk("R8", int'($signed(a_out[m])), 7, "value before edge");
      chk("R9", int'(a_sy[m]), 0, "sync before edge");
    end
    @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      chk("R8", int'($signed(a_out[m])), 3, "value after one edge");
      chk("R9", int'(a_sy[m]), 1, "sync after one edge");
    end
    a_in = 8'h00; sy = 1'b0;
    @(negedge clk);
    for (int m = 0; m < 4; m++) chk("R9", int'(a_sy[m]), 0, "sync falls with next sample");
  endtask

  // R10: enable low freezes data and sync
  task automatic t_hold();
    @(negedge clk);
    ce = 1'b0; a_in = 8'h70; sy = 1'b1;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      chk("R10", int'($signed(a_out[m])), 0, "data held");
      chk("R10", int'(a_sy[m]), 0, "sync held");
    end
    ce = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      chk("R10", int'($signed(a_out[m])), 7, "data after enable");
      chk("R10", int'(a_sy[m]), 1, "sync after enable");
    end
  endtask

  // R1: asynchronous reset drops a pending sync at once
  task automatic t_reset_mid();
    rst_n = 1'b0;
    #1;
    for (int m = 0; m < 4; m++) begin
      chk("R1", int'(a_sy[m]), 0, "sync cleared by reset");
      chk("R1", int'(a_out[m]), 0, "data cleared by reset");
    end
  endtask

  initial begin
    #(200000 * 20);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    t_reset_state();
    t_sweep_a();
    t_sweep_b();
    t_latency_sync();
    t_hold();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule